// File: doc/BRIEF.md
# Flash Programming Register Controller

This block sits between a processor's register bus and an on-chip flash array and lets software read single bytes, program single bytes and erase pages. Software loads a 16-bit target address as two byte registers, a data byte for programming, and a pulse-length value that it derives from the current clock frequency. It then sets one start bit in the control register. The controller drives a plain array interface with separate read, program and erase strobes. It holds the address and data steady for the whole operation and reports completion through busy and done flags.

Program and erase pulses last (timing value + 1) × PRESCALE clock cycles, so one parameter covers a wide range of clock rates. A read of the all-ones address never reaches the array: it returns the device option/configuration byte, which arrives on a dedicated input. A program or erase started before software has ever loaded the timing register is refused with an error flag, which protects the array from pulses of undefined width.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Register map on `reg_sel`: 0 = address high byte, 1 = address low byte, 2 = program data, 3 = read data (read only), 4 = timing, 5 = control. A write to 0, 1, 2 or 4 reads back the written byte. Control write bits: bit 0 starts a read, bit 1 starts a program, bit 2 starts an erase. Control read bits: bit 7 = busy, bit 5 = done, bit 4 = error, all other bits 0.
- R2: After reset both address bytes are 00, the timing register is marked unloaded, and busy, done, error and all three strobes are 0. The read data register has no defined reset value.
- R3: `fl_addr` always equals {high byte, low byte} of the address registers, with the high byte on bits 15:8, and it does not change while a strobe is active.
- R4: A read of any address other than FFFF asserts `fl_rd` for exactly one cycle and loads the read data register with `fl_rdata` from that cycle.
- R5: A read of address FFFF loads the read data register with `opt_cfg_byte` and never asserts `fl_rd`.
- R6: A program asserts `fl_prog` for exactly (timing + 1) × PRESCALE cycles with `fl_wdata` equal to the program data register. At most one strobe is ever active.
- R7: An erase asserts `fl_erase` for exactly (timing + 1) × PRESCALE cycles with `fl_addr` holding the page start address that software loaded.
- R8: Busy rises in the cycle after the accepting control write. Done rises, and busy falls, one cycle after the strobe deasserts. For a read this is the third cycle after the write. An accepted new command clears done.
- R9: A program or erase issued while the timing register has never been written sets error and asserts no strobe; busy stays 0. A read still runs. Any accepted command clears error.
- R10: While busy, writes to the address, program data and timing registers and to the control register are ignored.
- R11: When several start bits are written at once, read wins over program, and program wins over erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` (combinational) |
| opt_cfg_byte | input | 8 | Option/configuration byte returned for address FFFF |
| fl_addr | output | 16 | Array byte address |
| fl_wdata | output | 8 | Array program data |
| fl_rdata | input | 8 | Array read data, valid while `fl_rd` is high |
| fl_rd | output | 1 | Array read strobe |
| fl_prog | output | 1 | Array program strobe |
| fl_erase | output | 1 | Array page erase strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last accepted operation completed |
| err | output | 1 | Program/erase refused because timing was never loaded |

## Verification
The hardest state to reach is the untimed-refusal path. The timing register stays unloaded only between reset and its first write, so the bench runs its program and erase refusal checks before any timing write, and then shows that a read is still accepted and clears the error. The second awkward case is a register write that lands during a long pulse. A large timing value stretches the program pulse to 44 cycles, and the bench writes every register, including the control register, inside that pulse. It then reads back the registers and watches the array strobes to show that the operation ran unchanged and that no new command started.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
   // register select codes
   localparam logic [2:0] SEL_ADDR_HI = 3'd0;
   localparam logic [2:0] SEL_ADDR_LO = 3'd1;
   localparam logic [2:0] SEL_WDATA   = 3'd2;
   localparam logic [2:0] SEL_RDATA   = 3'd3;
   localparam logic [2:0] SEL_TIMING  = 3'd4;
   localparam logic [2:0] SEL_CTRL    = 3'd5;

   // control register bit positions
   localparam int CTL_GO_RD    = 0;
   localparam int CTL_GO_PROG  = 1;
   localparam int CTL_GO_ERASE = 2;
   localparam int CTL_ERR      = 4;
   localparam int CTL_DONE     = 5;
   localparam int CTL_BUSY     = 7;

   typedef enum logic [1:0] {OP_RD, OP_PROG, OP_ERASE} op_e;
   typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_PULSE, ST_GAP} st_e;
endpackage

// File: rtl/fpc_regs.sv
module fpc_regs
   import fpc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int TIM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              lock,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic [TIM_W-1:0]  timing_o,
   output logic              tim_loaded_o
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
         $error("fpc_regs: ADDR_W must be two data bytes");
      end
      if (TIM_W > DATA_W) begin : g_bad_tim
         $error("fpc_regs: TIM_W must fit one data word");
      end
   endgenerate

   logic [DATA_W-1:0] hi_q, lo_q, wd_q;
   logic [TIM_W-1:0]  tim_q;
   logic              loaded_q;
   logic              wr_ok;

   assign wr_ok = reg_wr && !lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= '0;
         lo_q     <= '0;
         wd_q     <= '0;
         tim_q    <= '0;
         loaded_q <= 1'b0;
      end else if (wr_ok) begin
         case (reg_sel)
            SEL_ADDR_HI: hi_q <= reg_wdata;
            SEL_ADDR_LO: lo_q <= reg_wdata;
            SEL_WDATA:   wd_q <= reg_wdata;
            SEL_TIMING: begin
               tim_q    <= reg_wdata[TIM_W-1:0];
               loaded_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign addr_o       = {hi_q, lo_q};
   assign wdata_o      = wd_q;
   assign timing_o     = tim_q;
   assign tim_loaded_o = loaded_q;

   // R10: register writes during an operation leave every operand unchanged
   assert_locked_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && reg_wr) |=> ($stable(addr_o) && $stable(wdata_o) && $stable(timing_o)));
endmodule

// File: rtl/fpc_timer.sv
module fpc_timer #(
   parameter int TIM_W    = 8,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TIM_W-1:0] timing,
   output logic             zero_o
);
   localparam int MAX_LEN = (1 << TIM_W) * PRESCALE;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);

   generate
      if (PRESCALE < 1) begin : g_bad_pre
         $error("fpc_timer: PRESCALE must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] len;
   logic [CNT_W-1:0] cnt_q;

   generate
      if ((PRESCALE & (PRESCALE - 1)) == 0) begin : g_shift
         assign len = (CNT_W'(timing) + CNT_W'(1)) << $clog2(PRESCALE);
      end else begin : g_mul
         assign len = (CNT_W'(timing) + CNT_W'(1)) * CNT_W'(PRESCALE);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= len - CNT_W'(1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
   import fpc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter bit RDATA_CLR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_valid,
   input  logic [2:0]        go_bits,
   input  logic              tim_loaded,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] opt_byte,
   input  logic [DATA_W-1:0] fl_rdata,
   input  logic              tmr_zero,
   output logic              tmr_load,
   output logic              fl_rd,
   output logic              fl_prog,
   output logic              fl_erase,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata
);
   st_e  state_q;
   op_e  op_q;
   logic done_q, err_q;
   logic pick_rd, pick_prog, pick_er, idle, opt_hit, cap;

   // priority: read, then program, then erase
   always_comb begin
      pick_rd   = go_valid &&  go_bits[CTL_GO_RD];
      pick_prog = go_valid && !go_bits[CTL_GO_RD] &&  go_bits[CTL_GO_PROG];
      pick_er   = go_valid && !go_bits[CTL_GO_RD] && !go_bits[CTL_GO_PROG] && go_bits[CTL_GO_ERASE];
   end

   assign idle     = (state_q == ST_IDLE);
   assign opt_hit  = (addr == '1);
   assign tmr_load = idle && (pick_prog || pick_er) && tim_loaded;
   assign cap      = (state_q == ST_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_RD;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (pick_rd) begin
                  state_q <= ST_READ;
                  op_q    <= OP_RD;
                  done_q  <= 1'b0;
                  err_q   <= 1'b0;
               end else if (pick_prog || pick_er) begin
                  done_q <= 1'b0;
                  if (tim_loaded) begin
                     state_q <= ST_PULSE;
                     op_q    <= pick_prog ? OP_PROG : OP_ERASE;
                     err_q   <= 1'b0;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_READ:  state_q <= ST_GAP;
            ST_PULSE: if (tmr_zero) state_q <= ST_GAP;
            ST_GAP: begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   generate
      if (RDATA_CLR) begin : g_rd_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   rdata <= '0;
            else if (cap) rdata <= opt_hit ? opt_byte : fl_rdata;
         end
      end else begin : g_rd_noclr
         always_ff @(posedge clk) begin
            if (cap) rdata <= opt_hit ? opt_byte : fl_rdata;
         end
      end
   endgenerate

   assign fl_rd    = (state_q == ST_READ) && !opt_hit;
   assign fl_prog  = (state_q == ST_PULSE) && (op_q == OP_PROG);
   assign fl_erase = (state_q == ST_PULSE) && (op_q == OP_ERASE);
   assign busy     = !idle;
   assign done     = done_q;
   assign err      = err_q;

   // R6: never more than one array strobe
   assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fl_rd, fl_prog, fl_erase}));
   // R9: no pulse before timing has been loaded
   assert_no_untimed_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tim_loaded |-> !(fl_prog || fl_erase));
   // R8: done and idle one cycle after a pulse ends
   assert_done_follows_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_prog || fl_erase) |=> (done && !busy));
   // R4: read strobe lasts a single cycle
   assert_read_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rd |=> !fl_rd);
   // R3: address held for the whole operation
   assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(addr));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
   import fpc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int TIM_W     = 8,
   parameter int PRESCALE  = 4,
   parameter bit RDATA_CLR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] opt_cfg_byte,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [DATA_W-1:0] fl_wdata,
   input  logic [DATA_W-1:0] fl_rdata,
   output logic              fl_rd,
   output logic              fl_prog,
   output logic              fl_erase,
   output logic              busy,
   output logic              done,
   output logic              err
);
   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("flash_prog_ctrl: control layout needs DATA_W >= 8");
      end
   endgenerate

   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata, rdata;
   logic [TIM_W-1:0]  timing;
   logic              tim_loaded, tmr_load, tmr_zero, go_valid;

   assign go_valid = reg_wr && (reg_sel == SEL_CTRL);

   fpc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIM_W(TIM_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .lock(busy), .addr_o(addr), .wdata_o(wdata),
      .timing_o(timing), .tim_loaded_o(tim_loaded));

   fpc_timer #(.TIM_W(TIM_W), .PRESCALE(PRESCALE)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .timing(timing), .zero_o(tmr_zero));

   fpc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RDATA_CLR(RDATA_CLR)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_valid(go_valid), .go_bits(reg_wdata[2:0]),
      .tim_loaded(tim_loaded), .addr(addr), .opt_byte(opt_cfg_byte),
      .fl_rdata(fl_rdata), .tmr_zero(tmr_zero), .tmr_load(tmr_load),
      .fl_rd(fl_rd), .fl_prog(fl_prog), .fl_erase(fl_erase),
      .busy(busy), .done(done), .err(err), .rdata(rdata));

   always_comb begin
      reg_rdata = '0;
      case (reg_sel)
         SEL_ADDR_HI: reg_rdata = addr[ADDR_W-1:DATA_W];
         SEL_ADDR_LO: reg_rdata = addr[DATA_W-1:0];
         SEL_WDATA:   reg_rdata = wdata;
         SEL_RDATA:   reg_rdata = rdata;
         SEL_TIMING:  reg_rdata = DATA_W'(timing);
         SEL_CTRL: begin
            reg_rdata[CTL_BUSY] = busy;
            reg_rdata[CTL_DONE] = done;
            reg_rdata[CTL_ERR]  = err;
         end
         default:     reg_rdata = '0;
      endcase
   end

   assign fl_addr  = addr;
   assign fl_wdata = wdata;
endmodule

// File: tb/test_flash_prog_ctrl.sv
module test_flash_prog_ctrl;
   import fpc_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_sel = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] opt_cfg_byte = 8'hC3;
   logic [15:0] fl_addr;
   logic [7:0] fl_wdata, fl_rdata;
   logic       fl_rd, fl_prog, fl_erase, busy, done, err;

   always #10 clk = ~clk;   // 50 MHz

   flash_prog_ctrl i_flash_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .opt_cfg_byte(opt_cfg_byte),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
      .fl_rd(fl_rd), .fl_prog(fl_prog), .fl_erase(fl_erase),
      .busy(busy), .done(done), .err(err));

   // byte-wide array model, 16-byte pages
   logic [7:0] mem [1024];
   initial for (int i = 0; i < 1024; i++) mem[i] = 8'(i) ^ 8'h5A;
   assign fl_rdata = mem[fl_addr[9:0]];
   always @(posedge clk) begin
      if (fl_prog) mem[fl_addr[9:0]] <= fl_wdata;
      if (fl_erase) for (int k = 0; k < 16; k++) mem[{fl_addr[9:4], 4'(k)}] <= 8'hFF;
   end

   int total = 0;
   int bad   = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] s, output logic [7:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   typedef struct packed {
      logic [1:0]  op;   // 0 read, 1 program, 2 erase
      logic [15:0] a;
      logic [7:0]  wd;
      logic [7:0]  tim;
      logic [15:0] w;    // expected strobe cycles
      logic [7:0]  er;   // expected read data
   } vec_t;

   localparam vec_t VEC [11] = '{
      '{2'd0, 16'h0010, 8'h00, 8'd0, 16'd1,  8'h4A},
      '{2'd1, 16'h0010, 8'h3C, 8'd2, 16'd12, 8'h00},
      '{2'd0, 16'h0010, 8'h00, 8'd2, 16'd1,  8'h3C},
      '{2'd2, 16'h0010, 8'h00, 8'd0, 16'd4,  8'h00},
      '{2'd0, 16'h0013, 8'h00, 8'd0, 16'd1,  8'hFF},
      '{2'd0, 16'h0020, 8'h00, 8'd0, 16'd1,  8'h7A},
      '{2'd0, 16'hFFFF, 8'h00, 8'd0, 16'd0,  8'hC3},
      '{2'd1, 16'h0123, 8'h81, 8'd5, 16'd24, 8'h00},
      '{2'd0, 16'h0123, 8'h00, 8'd5, 16'd1,  8'h81},
      '{2'd2, 16'h0120, 8'h00, 8'd1, 16'd8,  8'h00},
      '{2'd0, 16'h0123, 8'h00, 8'd1, 16'd1,  8'hFF}
   };

   initial begin
      #(20 * 100000);
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v8;
      repeat (3) @(negedge clk);
      // R2: reset state
      chk("R2 flags/strobes", {busy, done, err, fl_rd, fl_prog, fl_erase}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 flags after release", {busy, done, err}, 0);
      rd_reg(SEL_ADDR_HI, v8); chk("R2 addr hi", v8, 8'h00);
      rd_reg(SEL_ADDR_LO, v8); chk("R2 addr lo", v8, 8'h00);
      chk("R2 fl_addr", fl_addr, 16'h0000);

      // R1 / R3: readback and address composition
      wr_reg(SEL_ADDR_HI, 8'hA5);
      wr_reg(SEL_ADDR_LO, 8'h3C);
      wr_reg(SEL_WDATA, 8'h96);
      rd_reg(SEL_ADDR_HI, v8); chk("R1 hi readback", v8, 8'hA5);
      rd_reg(SEL_ADDR_LO, v8); chk("R1 lo readback", v8, 8'h3C);
      rd_reg(SEL_WDATA, v8);   chk("R1 wdata readback", v8, 8'h96);
      chk("R3 fl_addr", fl_addr, 16'hA53C);
      chk("R6 fl_wdata", fl_wdata, 8'h96);

      // R9: untimed program and erase refused
      wr_reg(SEL_CTRL, 8'h02);
      chk("R9 prog refused", {busy, err, fl_rd, fl_prog, fl_erase}, 5'b01000);
      @(negedge clk);
      chk("R9 no strobe later", {busy, fl_prog, fl_erase}, 0);
      rd_reg(SEL_CTRL, v8); chk("R1 R9 ctrl err bit", v8, 8'h10);
      wr_reg(SEL_CTRL, 8'h04);
      chk("R9 erase refused", {busy, err, fl_prog, fl_erase}, 4'b0100);
      wr_reg(SEL_CTRL, 8'h01);
      chk("R9 read runs, err cleared", {fl_rd, err, busy}, 3'b101);
      @(negedge clk);
      chk("R8 read done low", {done, busy}, 2'b01);
      @(negedge clk);
      chk("R8 read done on 3rd cycle", {done, busy}, 2'b10);
      rd_reg(SEL_RDATA, v8); chk("R4 untimed read data", v8, 8'h66);
      rd_reg(SEL_CTRL, v8);  chk("R1 ctrl done bit", v8, 8'h20);

      // table walk
      for (int i = 0; i < 11; i++) begin
         vec_t  v;
         int    win, hits, other, abad;
         string tag;
         v = VEC[i];
         tag = (v.op == 2'd1) ? "R6" : (v.op == 2'd2) ? "R7" :
               (v.a == 16'hFFFF) ? "R5" : "R4";
         wr_reg(SEL_TIMING, v.tim);
         wr_reg(SEL_ADDR_HI, v.a[15:8]);
         wr_reg(SEL_ADDR_LO, v.a[7:0]);
         wr_reg(SEL_WDATA, v.wd);
         wr_reg(SEL_CTRL, 8'(1) << v.op);
         win = (v.op == 2'd0) ? 1 : int'(v.w);
         hits = 0; other = 0; abad = 0;
         for (int j = 0; j < win; j++) begin
            logic mine;
            mine = (v.op == 2'd0) ? fl_rd : (v.op == 2'd1) ? fl_prog : fl_erase;
            if (mine) begin
               hits++;
               if (fl_addr !== v.a) abad++;
            end
            other += int'(fl_rd) + int'(fl_prog) + int'(fl_erase) - int'(mine);
            @(negedge clk);
         end
         chk({tag, " strobe width"}, hits, v.w);
         chk({tag, " other strobes"}, other, 0);
         chk("R3 addr held", abad, 0);
         chk("R8 strobe ended, done low", {done, fl_rd, fl_prog, fl_erase}, 0);
         @(negedge clk);
         chk("R8 done one cycle later", {done, busy}, 2'b10);
         if (v.op == 2'd0) begin
            rd_reg(SEL_RDATA, v8);
            chk({tag, " read data"}, v8, v.er);
         end
      end

      // R10: writes during a long pulse are ignored
      wr_reg(SEL_TIMING, 8'd10);
      wr_reg(SEL_ADDR_HI, 8'h02);
      wr_reg(SEL_ADDR_LO, 8'h00);
      wr_reg(SEL_WDATA, 8'h11);
      wr_reg(SEL_CTRL, 8'h02);
      wr_reg(SEL_ADDR_HI, 8'h55);
      wr_reg(SEL_ADDR_LO, 8'h66);
      wr_reg(SEL_WDATA, 8'h77);
      wr_reg(SEL_TIMING, 8'h01);
      wr_reg(SEL_CTRL, 8'h01);
      chk("R10 still programming", {busy, fl_prog, fl_rd}, 3'b110);
      chk("R10 addr unchanged", fl_addr, 16'h0200);
      chk("R10 data unchanged", fl_wdata, 8'h11);
      wait_done();
      rd_reg(SEL_ADDR_HI, v8); chk("R10 hi kept", v8, 8'h02);
      rd_reg(SEL_ADDR_LO, v8); chk("R10 lo kept", v8, 8'h00);
      rd_reg(SEL_WDATA, v8);   chk("R10 wdata kept", v8, 8'h11);
      rd_reg(SEL_TIMING, v8);  chk("R10 timing kept", v8, 8'd10);
      @(negedge clk);
      chk("R10 ignored start did not run", {busy, fl_rd}, 0);

      // R11: priority of start bits
      wr_reg(SEL_CTRL, 8'h07);
      chk("R11 read wins", {fl_rd, fl_prog, fl_erase}, 3'b100);
      chk("R8 done cleared by new command", done, 1'b0);
      wait_done();
      rd_reg(SEL_RDATA, v8); chk("R6 programmed byte", v8, 8'h11);
      wr_reg(SEL_WDATA, 8'h22);
      wr_reg(SEL_CTRL, 8'h06);
      chk("R11 program beats erase", {fl_rd, fl_prog, fl_erase}, 3'b010);
      wait_done();
      wr_reg(SEL_CTRL, 8'h01);
      wait_done();
      rd_reg(SEL_RDATA, v8); chk("R11 program not erase", v8, 8'h22);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule